// File: doc/BRIEF.md
# Dual-Lane Register ALU

This block is the register-file datapath of a small signal-processing accelerator. It holds two banks of eight 16-bit registers. An ALU reads two registers of one bank and writes the result back over the first of them. An external loader fills the registers. A plain read port lets the surrounding logic observe any register.

In single mode one operation runs on register i and register j of the chosen bank. The zero and negative flags then follow the result, for use by conditional execution. In paired mode the same operation runs on two lanes in one cycle: lane 0 works on the even register pair base (i, j) and lane 1 on (i+1, j+1). Each lane reports signed overflow on a flag of its own.

Top module: `dual_lane_alu`

## Requirements
- R1: While `rst` is high at a rising edge, all sixteen registers and all four flags become zero at that edge.
- R2: When `ld_valid` is high at a rising edge, `ld_data` is written into register `ld_idx` of bank `ld_bank` (0 = A, 1 = B) at that edge. `rd_data` shows register `rd_idx` of bank `rd_bank` combinationally.
- R3: Operation codes are 000 AND, 001 OR, 010 XOR, 011 SUB, 100 ADD. In single mode (`exec_paired` = 0) a valid operation writes Ri OP Rj into Ri of bank `exec_bank`, where i = `exec_dst_idx` and j = `exec_src_idx`. No other register changes.
- R4: SUB yields Ri minus Rj, and ADD yields Ri plus Rj, both modulo 2^16.
- R5: After a single-mode operation, Z is 1 exactly when the result is zero, and N equals result bit 15. V0 is the two's-complement signed overflow of ADD or SUB and is 0 for the logic operations. V1 keeps its value.
- R6: In paired mode both lanes are written at the same edge: Ri gets Ri OP Rj and Ri+1 gets Ri+1 OP Rj+1. All operands are the values held before that edge.
- R7: In paired mode bit 0 of `exec_dst_idx` and of `exec_src_idx` is ignored, so an odd index acts as the even index below it.
- R8: After a paired operation Z and N keep their values. V0 gets the overflow of lane 0 (register i) and V1 gets the overflow of lane 1 (register i+1).
- R9: An operation code of 101, 110 or 111 changes no register and no flag.
- R10: If a load and an operation write the same register at the same edge, the operation result is stored. A load to any other register in that cycle still lands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| exec_valid | input | 1 | Execute an operation this cycle |
| exec_paired | input | 1 | 1 = two-lane mode, 0 = single mode |
| exec_op | input | 3 | Operation code |
| exec_bank | input | 1 | Bank of both operands (0 = A, 1 = B) |
| exec_dst_idx | input | 3 | Index i (first operand and destination) |
| exec_src_idx | input | 3 | Index j (second operand) |
| ld_valid | input | 1 | Write `ld_data` into a register |
| ld_bank | input | 1 | Bank of the load |
| ld_idx | input | 3 | Register index of the load |
| ld_data | input | 16 | Load value |
| rd_bank | input | 1 | Bank of the read port |
| rd_idx | input | 3 | Register index of the read port |
| rd_data | output | 16 | Contents of the addressed register |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| flag_v0 | output | 1 | Overflow flag of lane 0 |
| flag_v1 | output | 1 | Overflow flag of lane 1 |

## Verification
A load and an ALU writeback can land in the same cycle. They may target the same register, a register the ALU is only reading, or the same index in the other bank. The bench provokes all three cases in directed vectors and again through random traffic that mixes loads with single and paired operations. After every clock edge a behavioural model compares all sixteen registers and the four flags. This shows whether the writeback won the collision and whether the operands were taken from the values held before that edge.

// File: rtl/dla_pkg.sv
`timescale 1ns/1ps
package dla_pkg;

    localparam int DATA_W  = 16;
    localparam int REG_CNT = 8;
    localparam int LANES   = 2;
    localparam int BANKS   = 2;
    localparam int OP_W    = 3;

    typedef enum logic [OP_W-1:0] {
        OP_AND = 3'd0,
        OP_OR  = 3'd1,
        OP_XOR = 3'd2,
        OP_SUB = 3'd3,
        OP_ADD = 3'd4
    } alu_op_e;

    typedef struct packed {
        logic [DATA_W-1:0] value;
        logic              ovf;
    } lane_res_t;

    function automatic logic op_defined(input logic [OP_W-1:0] op);
        return op <= OP_W'(OP_ADD);
    endfunction

    function automatic logic op_is_arith(input logic [OP_W-1:0] op);
        return (op == OP_W'(OP_SUB)) || (op == OP_W'(OP_ADD));
    endfunction

endpackage

// File: rtl/dla_lane_alu.sv
`timescale 1ns/1ps
module dla_lane_alu
    import dla_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic [OP_W-1:0] op,
    input  logic [DW-1:0]   opa,
    input  logic [DW-1:0]   opb,
    output logic [DW-1:0]   res,
    output logic            ovf
);

    logic          do_sub;
    logic [DW-1:0] opb_eff;
    logic [DW-1:0] sum;

    always_comb begin
        do_sub  = (op == OP_W'(OP_SUB));
        opb_eff = do_sub ? ~opb : opb;
        sum     = opa + opb_eff + DW'(do_sub);
        case (op)
            OP_W'(OP_AND): res = opa & opb;
            OP_W'(OP_OR):  res = opa | opb;
            OP_W'(OP_XOR): res = opa ^ opb;
            OP_W'(OP_SUB),
            OP_W'(OP_ADD): res = sum;
            default:       res = '0;
        endcase
        // Signed overflow: equal operand signs, differing result sign.
        ovf = op_is_arith(op) && (opa[DW-1] == opb_eff[DW-1]) && (sum[DW-1] != opa[DW-1]);
    end

endmodule

// File: rtl/dla_regbank.sv
`timescale 1ns/1ps
module dla_regbank
    import dla_pkg::*;
#(
    parameter  int DW   = DATA_W,
    parameter  int NREG = REG_CNT,
    parameter  int NWP  = LANES,
    localparam int IW   = $clog2(NREG)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NWP-1:0]           wr_en,
    input  logic [NWP-1:0][IW-1:0]   wr_idx,
    input  logic [NWP-1:0][DW-1:0]   wr_data,
    input  logic                     ld_en,
    input  logic [IW-1:0]            ld_idx,
    input  logic [DW-1:0]            ld_data,
    output logic [NREG-1:0][DW-1:0]  regs_q
);

    logic ld_clash;

    always_comb begin
        ld_clash = 1'b0;
        for (int p = 0; p < NWP; p++) begin
            if (wr_en[p] && wr_idx[p] == ld_idx) ld_clash = 1'b1;
        end
    end

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        logic [DW-1:0] nxt;
        always_comb begin
            nxt = regs_q[r];
            if (ld_en && ld_idx == IW'(r)) nxt = ld_data;
            // ALU writeback overrides a load to the same register
            for (int p = 0; p < NWP; p++) begin
                if (wr_en[p] && wr_idx[p] == IW'(r)) nxt = wr_data[p];
            end
        end
        always_ff @(posedge clk) begin
            if (rst) regs_q[r] <= '0;
            else     regs_q[r] <= nxt;
        end
    end

    AST_LOAD_LANDS: assert property (@(posedge clk) disable iff (rst)
        (ld_en && !ld_clash) |=> regs_q[$past(ld_idx)] == $past(ld_data)); // R2

    AST_LANES_DISTINCT: assert property (@(posedge clk) disable iff (rst)
        (wr_en[0] && wr_en[NWP-1] && NWP > 1) |-> wr_idx[0] != wr_idx[NWP-1]); // R7

endmodule

// File: rtl/dla_status.sv
`timescale 1ns/1ps
module dla_status
    import dla_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int NL = LANES
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          upd_zn,
    input  logic [DW-1:0] zn_src,
    input  logic [NL-1:0] upd_v,
    input  logic [NL-1:0] v_src,
    output logic          z_q,
    output logic          n_q,
    output logic [NL-1:0] v_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            z_q <= 1'b0;
            n_q <= 1'b0;
        end else if (upd_zn) begin
            z_q <= (zn_src == '0);
            n_q <= zn_src[DW-1];
        end
    end

    for (genvar l = 0; l < NL; l++) begin : g_v
        always_ff @(posedge clk) begin
            if (rst)           v_q[l] <= 1'b0;
            else if (upd_v[l]) v_q[l] <= v_src[l];
        end
    end

endmodule

// File: rtl/dual_lane_alu.sv
`timescale 1ns/1ps
module dual_lane_alu
    import dla_pkg::*;
#(
    parameter  int DW   = DATA_W,
    parameter  int NREG = REG_CNT,
    localparam int IW   = $clog2(NREG),
    localparam int NL   = LANES,
    localparam int NB   = BANKS,
    localparam int BW   = $clog2(NB)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            exec_valid,
    input  logic            exec_paired,
    input  logic [OP_W-1:0] exec_op,
    input  logic [BW-1:0]   exec_bank,
    input  logic [IW-1:0]   exec_dst_idx,
    input  logic [IW-1:0]   exec_src_idx,
    input  logic            ld_valid,
    input  logic [BW-1:0]   ld_bank,
    input  logic [IW-1:0]   ld_idx,
    input  logic [DW-1:0]   ld_data,
    input  logic [BW-1:0]   rd_bank,
    input  logic [IW-1:0]   rd_idx,
    output logic [DW-1:0]   rd_data,
    output logic            flag_z,
    output logic            flag_n,
    output logic            flag_v0,
    output logic            flag_v1
);

    localparam logic [IW-1:0] LANE_MASK = IW'(NL - 1);

    logic                              exec_go;
    logic [IW-1:0]                     dst_base, src_base;
    logic [NB-1:0][NREG-1:0][DW-1:0]   bank_q;
    logic [NL-1:0][IW-1:0]             lane_dst, lane_src;
    logic [NL-1:0]                     lane_on;
    lane_res_t [NL-1:0]                lane_out;
    logic [NL-1:0][DW-1:0]             lane_val;
    logic [NL-1:0]                     lane_ovf;
    logic [NL-1:0]                     flag_v;

    assign exec_go  = exec_valid && op_defined(exec_op);
    assign dst_base = exec_dst_idx & ~LANE_MASK;
    assign src_base = exec_src_idx & ~LANE_MASK;

    for (genvar l = 0; l < NL; l++) begin : g_lane
        logic [DW-1:0] opa, opb, res;
        logic          ovf;
        always_comb begin
            if (exec_paired) begin
                lane_dst[l] = dst_base | IW'(l);
                lane_src[l] = src_base | IW'(l);
                lane_on[l]  = exec_go;
            end else begin
                lane_dst[l] = exec_dst_idx;
                lane_src[l] = exec_src_idx;
                lane_on[l]  = exec_go && (l == 0);
            end
        end
        assign opa = bank_q[exec_bank][lane_dst[l]];
        assign opb = bank_q[exec_bank][lane_src[l]];

        dla_lane_alu #(.DW(DW)) i_alu (
            .op  (exec_op),
            .opa (opa),
            .opb (opb),
            .res (res),
            .ovf (ovf)
        );
        assign lane_out[l] = '{value: res, ovf: ovf};
        assign lane_val[l] = lane_out[l].value;
        assign lane_ovf[l] = lane_out[l].ovf;
    end

    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic [NL-1:0] wen;
        assign wen = (exec_bank == BW'(b)) ? lane_on : '0;
        dla_regbank #(.DW(DW), .NREG(NREG), .NWP(NL)) i_bank (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (wen),
            .wr_idx  (lane_dst),
            .wr_data (lane_val),
            .ld_en   (ld_valid && ld_bank == BW'(b)),
            .ld_idx  (ld_idx),
            .ld_data (ld_data),
            .regs_q  (bank_q[b])
        );
    end

    dla_status #(.DW(DW), .NL(NL)) i_status (
        .clk    (clk),
        .rst    (rst),
        .upd_zn (exec_go && !exec_paired),
        .zn_src (lane_val[0]),
        .upd_v  (lane_on),
        .v_src  (lane_ovf),
        .z_q    (flag_z),
        .n_q    (flag_n),
        .v_q    (flag_v)
    );

    assign rd_data = bank_q[rd_bank][rd_idx];
    assign flag_v0 = flag_v[0];
    assign flag_v1 = flag_v[NL-1];

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> !flag_z && !flag_n && !flag_v0 && !flag_v1); // R1

    AST_LOGIC_NO_OVF: assert property (@(posedge clk) disable iff (rst)
        (exec_valid && !exec_paired && exec_op <= OP_W'(OP_XOR)) |=> !flag_v0); // R5

    AST_SINGLE_V1_HOLD: assert property (@(posedge clk) disable iff (rst)
        (exec_valid && !exec_paired) |=> $stable(flag_v1)); // R5

    AST_PAIR_ZN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (exec_valid && exec_paired) |=> $stable(flag_z) && $stable(flag_n)); // R8

    AST_BADOP_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (exec_valid && !op_defined(exec_op)) |=>
            $stable(flag_z) && $stable(flag_n) && $stable(flag_v0) && $stable(flag_v1)); // R9

endmodule

// File: tb/test_dual_lane_alu.sv
`timescale 1ns/1ps
module test_dual_lane_alu;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        exec_valid = 1'b0, exec_paired = 1'b0, exec_bank = 1'b0;
    logic [2:0]  exec_op = '0, exec_dst_idx = '0, exec_src_idx = '0;
    logic        ld_valid = 1'b0, ld_bank = 1'b0;
    logic [2:0]  ld_idx = '0;
    logic [15:0] ld_data = '0;
    logic        rd_bank = 1'b0;
    logic [2:0]  rd_idx = '0;
    logic [15:0] rd_data;
    logic        flag_z, flag_n, flag_v0, flag_v1;

    int mreg [2][8];
    int mz, mn, mv0, mv1;
    int vectors = 0, misses = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    dual_lane_alu i_dual_lane_alu (
        .clk(clk), .rst(rst), .exec_valid(exec_valid), .exec_paired(exec_paired),
        .exec_op(exec_op), .exec_bank(exec_bank), .exec_dst_idx(exec_dst_idx),
        .exec_src_idx(exec_src_idx), .ld_valid(ld_valid), .ld_bank(ld_bank),
        .ld_idx(ld_idx), .ld_data(ld_data), .rd_bank(rd_bank), .rd_idx(rd_idx),
        .rd_data(rd_data), .flag_z(flag_z), .flag_n(flag_n),
        .flag_v0(flag_v0), .flag_v1(flag_v1)
    );

    function automatic int calc(input int op, input int a, input int b, output int ov);
        int sa, sb, s;
        sa = (a >= 32768) ? a - 65536 : a;
        sb = (b >= 32768) ? b - 65536 : b;
        ov = 0;
        case (op)
            0: return a & b;
            1: return a | b;
            2: return a ^ b;
            3: begin s = sa - sb; ov = (s > 32767 || s < -32768); return (a - b) & 16'hFFFF; end
            default: begin s = sa + sb; ov = (s > 32767 || s < -32768); return (a + b) & 16'hFFFF; end
        endcase
    endfunction

    task automatic fail(input string tag, input string what, input int act, input int exp);
        misses++;
        $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    endtask

    task automatic compare(input string tag);
        vectors++;
        if (flag_z  !== 1'(mz))  fail(tag, "flag_z",  flag_z,  mz);
        if (flag_n  !== 1'(mn))  fail(tag, "flag_n",  flag_n,  mn);
        if (flag_v0 !== 1'(mv0)) fail(tag, "flag_v0", flag_v0, mv0);
        if (flag_v1 !== 1'(mv1)) fail(tag, "flag_v1", flag_v1, mv1);
        for (int b = 0; b < 2; b++) begin
            for (int i = 0; i < 8; i++) begin
                rd_bank = 1'(b);
                rd_idx  = 3'(i);
                #0.1;
                if (rd_data !== 16'(mreg[b][i]))
                    fail(tag, $sformatf("reg[%0d][%0d]", b, i), rd_data, mreg[b][i]);
            end
        end
    endtask

    // One clock: drive at the falling edge, update model at the rising edge, compare after it
    task automatic vec(input string tag, input bit rs, input bit xv, input bit pr, input int op,
                       input int bk, input int di, input int si,
                       input bit lv, input int lb, input int li, input int ld);
        int nreg [2][8];
        int r, ov, i0, j0;
        @(negedge clk);
        rst = rs; exec_valid = xv; exec_paired = pr; exec_op = 3'(op); exec_bank = 1'(bk);
        exec_dst_idx = 3'(di); exec_src_idx = 3'(si);
        ld_valid = lv; ld_bank = 1'(lb); ld_idx = 3'(li); ld_data = 16'(ld);
        nreg = mreg;
        if (rs) begin
            foreach (nreg[b, i]) nreg[b][i] = 0;
            mz = 0; mn = 0; mv0 = 0; mv1 = 0;
        end else begin
            if (lv) nreg[lb][li] = ld;
            if (xv && op <= 4) begin
                if (pr) begin
                    i0 = di & 6; j0 = si & 6;
                    r = calc(op, mreg[bk][i0], mreg[bk][j0], ov);
                    nreg[bk][i0] = r; mv0 = ov;
                    r = calc(op, mreg[bk][i0+1], mreg[bk][j0+1], ov);
                    nreg[bk][i0+1] = r; mv1 = ov;
                end else begin
                    r = calc(op, mreg[bk][di], mreg[bk][si], ov);
                    nreg[bk][di] = r;
                    mz = (r == 0); mn = (r >= 32768); mv0 = ov;
                end
            end
        end
        @(posedge clk);
        mreg = nreg;
        #1;
        compare(tag);
    endtask

    task automatic load(input int b, input int i, input int d);
        vec("R2", 0, 0, 0, 0, 0, 0, 0, 1, b, i, d);
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            misses++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        foreach (mreg[b, i]) mreg[b][i] = 0;
        mz = 0; mn = 0; mv0 = 0; mv1 = 0;
        vec("R1", 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        vec("R1", 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 8; i++) begin
            load(0, i, 16'h1111 * (i + 1));
            load(1, i, 16'h0F0F ^ (i * 16'h0123));
        end
        // R3: each logic operation, single mode, bank A and bank B
        vec("R3", 0, 1, 0, 0, 0, 1, 2, 0, 0, 0, 0);
        vec("R3", 0, 1, 0, 1, 1, 3, 4, 0, 0, 0, 0);
        vec("R3", 0, 1, 0, 2, 0, 5, 5, 0, 0, 0, 0);   // R5: XOR with itself sets Z
        // R4/R5: add and subtract with signed overflow
        load(0, 0, 16'h7FFF); load(0, 1, 16'h0001);
        vec("R4", 0, 1, 0, 4, 0, 0, 1, 0, 0, 0, 0);   // 0x8000, N and V0
        load(0, 2, 16'h8000); load(0, 3, 16'h0001);
        vec("R4", 0, 1, 0, 3, 0, 2, 3, 0, 0, 0, 0);   // 0x7FFF, V0 set
        vec("R5", 0, 1, 0, 0, 0, 2, 3, 0, 0, 0, 0);   // logic clears V0
        vec("R4", 0, 1, 0, 3, 0, 4, 4, 0, 0, 0, 0);   // Ri - Ri = 0
        // R6/R8: paired, overflow only on lane 1
        load(1, 0, 16'h0005); load(1, 1, 16'h7000);
        load(1, 2, 16'h0003); load(1, 3, 16'h2000);
        vec("R8", 0, 1, 1, 4, 1, 0, 2, 0, 0, 0, 0);
        vec("R6", 0, 1, 1, 3, 1, 2, 0, 0, 0, 0, 0);
        // R7: odd indices masked to the even one below
        vec("R7", 0, 1, 1, 2, 0, 5, 7, 0, 0, 0, 0);
        vec("R7", 0, 1, 1, 4, 1, 7, 1, 0, 0, 0, 0);
        // R9: undefined codes
        for (int op = 5; op < 8; op++) vec("R9", 0, 1, op[0], op, op & 1, 0, 1, 0, 0, 0, 0);
        // R10: collisions between load and writeback
        vec("R10", 0, 1, 0, 4, 0, 6, 7, 1, 0, 6, 16'hDEAD);
        vec("R10", 0, 1, 0, 1, 0, 6, 7, 1, 0, 7, 16'hBEEF);
        vec("R10", 0, 1, 1, 0, 1, 4, 6, 1, 1, 5, 16'h1234);
        vec("R10", 0, 1, 1, 2, 1, 2, 0, 1, 0, 2, 16'h5678);
        // Random traffic
        for (int k = 0; k < 600; k++) begin
            int op, pr;
            op = $urandom_range(0, 7);
            pr = $urandom_range(0, 1);
            vec(pr ? "R6" : (op > 4 ? "R9" : "R3"), 0, 1'($urandom_range(0, 3) != 0), 1'(pr), op,
                $urandom_range(0, 1), $urandom_range(0, 7), $urandom_range(0, 7),
                1'($urandom_range(0, 1)), $urandom_range(0, 1), $urandom_range(0, 7),
                $urandom_range(0, 65535));
        end
        // R1: reset in the middle of activity clears everything
        vec("R1", 1, 1, 0, 4, 0, 1, 2, 1, 1, 3, 16'hFFFF);
        vec("R1", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule